// File: doc/BRIEF.md
# Pin-Masked GPIO Controller with Interrupt Detection

This block is an eight-pin general-purpose I/O peripheral that sits on a simple register bus with separate select, write-enable, address and data signals. Each pin is an input or an output, set by its own direction bit. The output data register is reached through an address window whose word-address bits act as a pin mask. A bus write changes only the pins whose mask bit is set, so software can update one pin without a read-modify-write. A bus read through the same window returns zero for unmasked pins. For an output pin it returns the driven value, and for an input pin it returns the synchronised pad value.

Each pin also feeds an interrupt detector. The detector senses a level or a single edge of either polarity, or both edges. Edge events stay latched until software clears them by writing ones to the clear register. Level events follow the live input. Raw status, masked status (raw AND enable) and a single OR-combined interrupt line are provided. Pad inputs pass through a two-flop synchroniser before any detection. Bus reads are registered and return data one clock after the request.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every direction bit, output value, sense, both-edge, polarity and enable bit is 0, `pin_oe` and `pin_out` are 0, and `irq` is low.
- R2: The direction register at byte offset 0x400 reads back as written, and `pin_oe` equals it; a 1 makes the pin an output.
- R3: A write to byte offsets 0x000–0x3FC updates output bit i only when address bit i+2 is 1; bits with a 0 mask bit keep their value.
- R4: A data write leaves `pin_out` unchanged for every pin whose direction bit is 0. After that pin becomes an output, it drives its earlier value until it is written again.
- R5: A read of 0x000–0x3FC returns 0 for pins whose mask bit (address bit i+2) is 0. It returns the output value for masked output pins and the synchronised input for masked input pins. Read data appears on `bus_rdata` one clock after the request.
- R6: With sense bit 1 (0x404), raw status follows the synchronised input: high when the input equals the polarity bit (0x40C, 1 = high level), low otherwise. Writing the clear register does not remove it while the level persists.
- R7: With sense bit 0 and both-edge bit 0 (0x408), polarity 1 latches raw status on a rising edge and polarity 0 on a falling edge; the opposite edge does not set it.
- R8: With sense 0 and both-edge bit 1, either edge latches raw status, whatever the polarity bit.
- R9: Writing 1 to a bit of 0x41C clears that pin's latched edge status, and writing 0 leaves it set. An edge detected in the same cycle as the clear keeps the bit set.
- R10: Raw status reads at 0x414, masked status at 0x418 equals raw AND enable (0x410), and `irq` is the OR of the masked bits.
- R11: A pad change that forms a qualifying edge sets the latched status, and so `irq` when enabled, at the third rising clock edge after the change, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read request |
| pin_in | input | 8 | Pad input values (asynchronous) |
| pin_out | output | 8 | Output data register |
| pin_oe | output | 8 | Output enable per pin (direction register) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench writes data to pins that are still inputs and checks that `pin_out` does not move, including after the direction changes. A design that let those writes through would drive stale values the moment a pin turned output. It times an enabled edge against the clock to catch a missing or extra synchroniser stage. It also places a clear write in the very cycle that a new edge is detected. A design that gave the clear priority would lose that interrupt. It also writes the clear register while a level condition is active and expects the status to stay set, and it drives the opposite edge to a single-edge pin, which a design that ignored polarity would latch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Control registers occupy one 32-byte block; word index = addr[4:2]
    localparam logic [11:0] CTL_BASE = 12'h400;

    typedef enum logic [2:0] {
        CW_DIR    = 3'd0,
        CW_SENSE  = 3'd1,
        CW_BOTH   = 3'd2,
        CW_POLAR  = 3'd3,
        CW_ENABLE = 3'd4,
        CW_RAW    = 3'd5,
        CW_MASKED = 3'd6,
        CW_CLEAR  = 3'd7
    } ctl_word_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[k] <= '0;
            else        stage[k] <= stage[k-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] sin,
    input  logic [NPIN-1:0] sense_lvl,
    input  logic [NPIN-1:0] both_edge,
    input  logic [NPIN-1:0] polar_hi,
    input  logic [NPIN-1:0] clr,
    output logic [NPIN-1:0] raw
);
    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] edge_q;
    logic [NPIN-1:0] rise, fall, hit, lvl;

    always_comb begin
        rise = sin & ~prev_q;
        fall = ~sin & prev_q;
        hit  = ~sense_lvl & ((both_edge & (rise | fall)) |
                             (~both_edge & ((polar_hi & rise) | (~polar_hi & fall))));
        lvl  = ~(sin ^ polar_hi);
        raw  = (sense_lvl & lvl) | (~sense_lvl & edge_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            edge_q <= '0;
        end else begin
            prev_q <= sin;
            edge_q <= hit | (edge_q & ~clr);
        end
    end

    AST_CLEAR_ONLY_W1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_q) & ~edge_q & ~$past(clr)) == '0); // R9
    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_q & ~$past(edge_q) & ~($past(sin) ^ $past(prev_q))) == '0); // R7
    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_q & ~$past(edge_q) & $past(sense_lvl)) == '0); // R6
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned NPIN = 8,
    parameter int unsigned AW   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] sin,
    input  logic [NPIN-1:0] raw,
    input  logic [NPIN-1:0] masked,
    output logic [NPIN-1:0] dir,
    output logic [NPIN-1:0] dout,
    output logic [NPIN-1:0] sense_lvl,
    output logic [NPIN-1:0] both_edge,
    output logic [NPIN-1:0] polar_hi,
    output logic [NPIN-1:0] enable,
    output logic [NPIN-1:0] clr
);
    localparam int unsigned MSB_LO = NPIN + 2;

    logic            wr_en, rd_en, in_data, in_ctl;
    logic [NPIN-1:0] pmask, wmask, rd_val;
    ctl_word_e       word;

    always_comb begin
        wr_en   = bus_sel & bus_wr;
        rd_en   = bus_sel & ~bus_wr;
        in_data = (bus_addr[AW-1:10] == '0);
        in_ctl  = (bus_addr[AW-1:5] == CTL_BASE[AW-1:5]);
        word    = ctl_word_e'(bus_addr[4:2]);
        pmask   = bus_addr[MSB_LO-1:2];
        wmask   = (wr_en && in_data) ? (pmask & dir) : '0;
        clr     = (wr_en && in_ctl && word == CW_CLEAR) ? bus_wdata : '0;
    end

    always_comb begin
        rd_val = '0;
        if (in_data) begin
            rd_val = pmask & ((dir & dout) | (~dir & sin));
        end else if (in_ctl) begin
            unique case (word)
                CW_DIR:    rd_val = dir;
                CW_SENSE:  rd_val = sense_lvl;
                CW_BOTH:   rd_val = both_edge;
                CW_POLAR:  rd_val = polar_hi;
                CW_ENABLE: rd_val = enable;
                CW_RAW:    rd_val = raw;
                CW_MASKED: rd_val = masked;
                CW_CLEAR:  rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir       <= '0;
            dout      <= '0;
            sense_lvl <= '0;
            both_edge <= '0;
            polar_hi  <= '0;
            enable    <= '0;
            bus_rdata <= '0;
        end else begin
            dout <= (dout & ~wmask) | (bus_wdata & wmask);
            if (wr_en && in_ctl) begin
                unique case (word)
                    CW_DIR:    dir       <= bus_wdata;
                    CW_SENSE:  sense_lvl <= bus_wdata;
                    CW_BOTH:   both_edge <= bus_wdata;
                    CW_POLAR:  polar_hi  <= bus_wdata;
                    CW_ENABLE: enable    <= bus_wdata;
                    default:   ;
                endcase
            end
            if (rd_en) bus_rdata <= rd_val;
        end
    end

    logic            rd_data_hit;
    logic [NPIN-1:0] wr_pmask;
    assign rd_data_hit = rd_en & in_data;
    assign wr_pmask    = (wr_en && in_data) ? pmask : '0;

    AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((dout ^ $past(dout)) & ~$past(dir)) == '0); // R4
    AST_DATA_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((dout ^ $past(dout)) & ~$past(wr_pmask)) == '0); // R3
    AST_RD_UNMASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_data_hit) |-> ((bus_rdata & ~$past(pmask)) == '0)); // R5
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
    parameter int unsigned NPIN = 8,
    parameter int unsigned AW   = 12,
    parameter int unsigned SYNC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            irq
);
    logic [NPIN-1:0] sin, raw, masked;
    logic [NPIN-1:0] dir, dout, sense_lvl, both_edge, polar_hi, enable, clr;

    gpio_sync #(.WIDTH(NPIN), .STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sin)
    );

    gpio_regs #(.NPIN(NPIN), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sin(sin), .raw(raw), .masked(masked),
        .dir(dir), .dout(dout), .sense_lvl(sense_lvl), .both_edge(both_edge),
        .polar_hi(polar_hi), .enable(enable), .clr(clr)
    );

    gpio_irq_detect #(.NPIN(NPIN)) u_det (
        .clk(clk), .rst_n(rst_n), .sin(sin),
        .sense_lvl(sense_lvl), .both_edge(both_edge), .polar_hi(polar_hi),
        .clr(clr), .raw(raw)
    );

    assign masked  = raw & enable;
    assign irq     = |masked;
    assign pin_out = dout;
    assign pin_oe  = dir;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq); // R10
    AST_OE_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && bus_wr) |-> $stable(pin_oe)); // R2
endmodule

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic       irq;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       capt = 1'b0;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected item for each completed read
    always @(posedge clk) capt <= bus_sel && !bus_wr;
    always @(negedge clk) begin
        if (capt) begin
            if (exp_q.size() == 0) chk("scoreboard-empty", 8'h01, 8'h00);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(logic [11:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    // Driver: issues a read and pushes its expected value
    task automatic rd(logic [11:0] a, logic [7:0] e, string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic drive(logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rd(12'h410, 8'h00, "R1 enable");
        rd(12'h404, 8'h00, "R1 sense");
        // R4 writes to inputs ignored
        wr(12'h3FC, 8'hFF);
        @(negedge clk); chk("R4 input write", pin_out, 8'h00);
        wr(12'h400, 8'h0F);
        @(negedge clk); chk("R4 after dir", pin_out, 8'h00);
        chk("R2 pin_oe", pin_oe, 8'h0F);
        rd(12'h400, 8'h0F, "R2 dir readback");
        wr(12'h3FC, 8'hFF);
        @(negedge clk); chk("R4 rewrite", pin_out, 8'h0F);
        // R3 address mask
        wr(12'h00C, 8'h00);
        @(negedge clk); chk("R3 mask 03", pin_out, 8'h0C);
        wr(12'h014, 8'h01);
        @(negedge clk); chk("R3 mask 05", pin_out, 8'h09);
        // R5 masked reads
        drive(8'hA0);
        rd(12'h3FC, 8'hA9, "R5 all");
        rd(12'h3C0, 8'hA0, "R5 upper");
        rd(12'h004, 8'h01, "R5 pin0");
        rd(12'h000, 8'h00, "R5 none");
        // R7 falling mode ignores rising
        rd(12'h414, 8'h00, "R7 rising ignored");
        drive(8'h80);
        rd(12'h414, 8'h20, "R7 falling");
        wr(12'h41C, 8'h00);
        rd(12'h414, 8'h20, "R9 write zero");
        wr(12'h41C, 8'h20);
        rd(12'h414, 8'h00, "R9 clear");
        wr(12'h40C, 8'h10);
        drive(8'h10);
        rd(12'h414, 8'h90, "R7 rise4 fall7");
        wr(12'h41C, 8'hFF);
        rd(12'h414, 8'h00, "R9 clear all");
        // R8 both edges
        wr(12'h408, 8'h40);
        wr(12'h40C, 8'h50);
        drive(8'h50);
        rd(12'h414, 8'h40, "R8 rise");
        wr(12'h41C, 8'h40);
        drive(8'h10);
        rd(12'h414, 8'h40, "R8 fall");
        wr(12'h41C, 8'h40);
        rd(12'h414, 8'h00, "R8 cleared");
        // R6 level
        wr(12'h404, 8'h80);
        rd(12'h414, 8'h80, "R6 low level");
        wr(12'h41C, 8'h80);
        rd(12'h414, 8'h80, "R6 not clearable");
        drive(8'h90);
        rd(12'h414, 8'h00, "R6 level gone");
        wr(12'h40C, 8'hD0);
        rd(12'h414, 8'h80, "R6 high level");
        // R10 masking
        wr(12'h410, 8'h80);
        rd(12'h418, 8'h80, "R10 masked");
        @(negedge clk); chk("R10 irq on", {7'b0, irq}, 8'h01);
        wr(12'h410, 8'h00);
        rd(12'h418, 8'h00, "R10 masked off");
        rd(12'h414, 8'h80, "R10 raw kept");
        @(negedge clk); chk("R10 irq off", {7'b0, irq}, 8'h00);
        wr(12'h404, 8'h00);
        drive(8'h00);
        wr(12'h41C, 8'hFF);
        rd(12'h414, 8'h00, "R7 rising mode no fall");
        // R11 latency
        wr(12'h410, 8'h10);
        @(negedge clk); pin_in = 8'h10;
        @(posedge clk); @(posedge clk);
        @(negedge clk); chk("R11 not at 2nd edge", {7'b0, irq}, 8'h00);
        @(posedge clk);
        @(negedge clk); chk("R11 at 3rd edge", {7'b0, irq}, 8'h01);
        // R9 clear vs simultaneous edge
        drive(8'h00);
        @(negedge clk); pin_in = 8'h10;
        @(posedge clk); @(posedge clk);
        wr(12'h41C, 8'h10);
        rd(12'h414, 8'h10, "R9 edge beats clear");
        @(negedge clk); chk("R9 irq kept", {7'b0, irq}, 8'h01);
        wr(12'h41C, 8'h10);
        rd(12'h414, 8'h00, "R9 later clear");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule